// File: doc/BRIEF.md
# Masked Bit Test-and-Branch Unit

This block carries out the data path and decision of three byte-wide bit instructions. The first branches when every masked bit of an operand is clear. The second branches when every masked bit is set. The third ORs a mask into an operand and writes the result back. Address generation and memory sequencing live outside the block. The sequencer pulses `start` with the opcode, the addressing class, the mask, the displacement, the program counter and the condition codes. It then supplies the operand byte on `m_in`. The block answers with the branch decision, the following program counter and, for the set operation, a one-cycle write strobe with the byte to store.

A small state machine steps through the instruction. The states are S_IDLE, S_READ, S_EVAL, S_WRITE and S_FIN, with these transitions:

- S_IDLE to S_READ on an accepted start.
- S_READ to S_EVAL, which captures the operand byte.
- S_EVAL to S_WRITE for the set operation, or to S_FIN for the two branches. This transition registers the decision, the next PC, the write byte and the flags.
- S_WRITE to S_FIN, which strobes the write.
- S_FIN to S_IDLE, which pulses `done`.

The results stay on the outputs until the next instruction is accepted.

Top module: `bitbr_unit`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `wr_en` are 0.
- R2: A start is accepted only when the opcode belongs to one of three groups and the addressing class matches its high nibble. The groups are branch-if-clear (0x4F, 0x1F, 0x0F), branch-if-set (0x4E, 0x1E, 0x0E) and set-bits (0x4C, 0x1C, 0x0C). The class codes are 0 direct, 1 extended, 2 indexed without extra offset, 3 indexed with 9-bit offset and 4 indexed with 16-bit offset. High nibble 4 needs class 0, high nibble 1 needs class 1, and high nibble 0 needs class 2, 3 or 4. Any other start is ignored: `busy` stays 0 and no `done` or `wr_en` follows.
- R3: Branch-if-clear is taken exactly when (M AND mask) is 0.
- R4: Branch-if-set is taken exactly when (NOT M AND mask) is 0.
- R5: For both branches the instruction length is 4, 5, 4, 5 or 6 bytes for classes 0 to 4. `next_pc` is PC plus the length, plus the sign-extended displacement when taken, modulo 2^16.
- R6: For set-bits the length is 3, 4, 3, 4 or 5 bytes for classes 0 to 4. `taken` is 0 and `next_pc` is PC plus the length.
- R7: Only set-bits raises `wr_en`, for exactly one cycle, with `wr_data` = M OR mask.
- R8: `ccr_out` is {N,Z,V,C} (bit 3 down to bit 0). For set-bits, N is bit 7 of the result, Z is 1 when the result is 0, V is 0 and C is copied from `ccr_in`. Both branches return `ccr_in` unchanged.
- R9: `done` is a one-cycle pulse. Counting the accepting edge as 0, `done` is high after edge 2 for a branch and after edge 3 for set-bits. A start while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction when idle |
| opcode | input | 8 | Instruction opcode |
| amode | input | 3 | Addressing class code |
| m_in | input | 8 | Operand byte, sampled in S_READ |
| mask | input | 8 | Mask byte |
| disp | input | 8 | Signed branch displacement |
| pc_in | input | 16 | Address of the instruction |
| ccr_in | input | 4 | Incoming flags {N,Z,V,C} |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision |
| next_pc | output | 16 | Following program counter |
| wr_en | output | 1 | Write-back strobe |
| wr_data | output | 8 | Write-back byte |
| ccr_out | output | 4 | Resulting flags {N,Z,V,C} |

## Verification
Each branch is tried three ways: with operands whose masked bits are all clear, all set, or mixed, and with a zero mask. This separates the clear test from the set test and catches an inverted or unmasked comparison. Every addressing class is used, and negative displacements that wrap past address zero expose errors in length and sign extension. Set-bits runs with results that are zero and that have bit 7 set, so the Z and N updates and the kept carry can be told apart. Rejected opcodes, mismatched classes and a start raised during an instruction show that the sequencer ignores them.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;
    localparam int LEN_W = 3;

    localparam logic [2:0] AM_DIR   = 3'd0;
    localparam logic [2:0] AM_EXT   = 3'd1;
    localparam logic [2:0] AM_IDX   = 3'd2;
    localparam logic [2:0] AM_IDX9  = 3'd3;
    localparam logic [2:0] AM_IDX16 = 3'd4;

    typedef enum logic [1:0] {
        OPK_BRCLR,
        OPK_BRSET,
        OPK_BSET,
        OPK_NONE
    } opk_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_EVAL,
        S_WRITE,
        S_FIN
    } state_e;
endpackage

// File: rtl/bitbr_decode.sv
module bitbr_decode
    import bitbr_pkg::*;
(
    input  logic [7:0]       opcode,
    input  logic [2:0]       amode,
    output logic             legal,
    output opk_e             kind,
    output logic [LEN_W-1:0] len
);
    logic             mode_ok;
    logic [LEN_W-1:0] base_len;

    always_comb begin
        unique case (opcode[3:0])
            4'hF:    kind = OPK_BRCLR;
            4'hE:    kind = OPK_BRSET;
            4'hC:    kind = OPK_BSET;
            default: kind = OPK_NONE;
        endcase
    end

    always_comb begin
        unique case (opcode[7:4])
            4'h4:    mode_ok = (amode == AM_DIR);
            4'h1:    mode_ok = (amode == AM_EXT);
            4'h0:    mode_ok = (amode == AM_IDX) || (amode == AM_IDX9) || (amode == AM_IDX16);
            default: mode_ok = 1'b0;
        endcase
    end

    always_comb begin
        unique case (amode)
            AM_EXT, AM_IDX9: base_len = LEN_W'(5);
            AM_IDX16:        base_len = LEN_W'(6);
            default:         base_len = LEN_W'(4);
        endcase
    end

    assign len   = (kind == OPK_BSET) ? base_len - LEN_W'(1) : base_len;
    assign legal = mode_ok && (kind != OPK_NONE);
endmodule

// File: rtl/bitbr_eval.sv
module bitbr_eval
    import bitbr_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  opk_e             kind,
    input  logic [DW-1:0]    m,
    input  logic [DW-1:0]    mask,
    input  logic [DW-1:0]    disp,
    input  logic [AW-1:0]    pc,
    input  logic [LEN_W-1:0] len,
    input  logic [3:0]       ccr_i,
    output logic             taken,
    output logic [AW-1:0]    npc,
    output logic [DW-1:0]    wdata,
    output logic [3:0]       ccr_o
);
    logic [DW-1:0] hit_clr;
    logic [DW-1:0] hit_set;
    logic [AW-1:0] disp_ext;
    logic [AW-1:0] seq_pc;

    assign hit_clr  = m & mask;
    assign hit_set  = ~m & mask;
    assign disp_ext = {{(AW-DW){disp[DW-1]}}, disp};
    assign seq_pc   = pc + AW'(len);
    assign wdata    = m | mask;

    always_comb begin
        unique case (kind)
            OPK_BRCLR: taken = (hit_clr == '0);
            OPK_BRSET: taken = (hit_set == '0);
            default:   taken = 1'b0;
        endcase
    end

    assign npc   = taken ? seq_pc + disp_ext : seq_pc;
    assign ccr_o = (kind == OPK_BSET) ? {wdata[DW-1], (wdata == '0), 1'b0, ccr_i[0]} : ccr_i;
endmodule

// File: rtl/bitbr_unit.sv
module bitbr_unit
    import bitbr_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [2:0]    amode,
    input  logic [DW-1:0] m_in,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] disp,
    input  logic [AW-1:0] pc_in,
    input  logic [3:0]    ccr_in,
    output logic          busy,
    output logic          done,
    output logic          taken,
    output logic [AW-1:0] next_pc,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic [3:0]    ccr_out
);
    state_e           state, state_nx;
    logic             dec_legal;
    opk_e             dec_kind;
    logic [LEN_W-1:0] dec_len;

    opk_e             kind_q;
    logic [LEN_W-1:0] len_q;
    logic [DW-1:0]    mask_q, disp_q, m_q;
    logic [AW-1:0]    pc_q;
    logic [3:0]       ccr_q;

    logic             ev_taken;
    logic [AW-1:0]    ev_npc;
    logic [DW-1:0]    ev_wdata;
    logic [3:0]       ev_ccr;

    logic             taken_q;
    logic [AW-1:0]    npc_q;
    logic [DW-1:0]    wdata_q;
    logic [3:0]       ccrout_q;

    logic             accept;

    bitbr_decode u_decode (
        .opcode (opcode),
        .amode  (amode),
        .legal  (dec_legal),
        .kind   (dec_kind),
        .len    (dec_len)
    );

    bitbr_eval #(.DW(DW), .AW(AW)) u_eval (
        .kind  (kind_q),
        .m     (m_q),
        .mask  (mask_q),
        .disp  (disp_q),
        .pc    (pc_q),
        .len   (len_q),
        .ccr_i (ccr_q),
        .taken (ev_taken),
        .npc   (ev_npc),
        .wdata (ev_wdata),
        .ccr_o (ev_ccr)
    );

    assign accept = (state == S_IDLE) && start && dec_legal;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (accept) state_nx = S_READ;
            S_READ:  state_nx = S_EVAL;
            S_EVAL:  state_nx = (kind_q == OPK_BSET) ? S_WRITE : S_FIN;
            S_WRITE: state_nx = S_FIN;
            S_FIN:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= OPK_NONE;
            len_q    <= '0;
            mask_q   <= '0;
            disp_q   <= '0;
            m_q      <= '0;
            pc_q     <= '0;
            ccr_q    <= '0;
            taken_q  <= 1'b0;
            npc_q    <= '0;
            wdata_q  <= '0;
            ccrout_q <= '0;
        end else begin
            if (accept) begin
                kind_q <= dec_kind;
                len_q  <= dec_len;
                mask_q <= mask;
                disp_q <= disp;
                pc_q   <= pc_in;
                ccr_q  <= ccr_in;
            end
            if (state == S_READ) m_q <= m_in;
            if (state == S_EVAL) begin
                taken_q  <= ev_taken;
                npc_q    <= ev_npc;
                wdata_q  <= ev_wdata;
                ccrout_q <= ev_ccr;
            end
        end
    end

    always_comb begin
        busy    = (state != S_IDLE);
        done    = (state == S_FIN);
        wr_en   = (state == S_WRITE);
        taken   = taken_q;
        next_pc = npc_q;
        wr_data = wdata_q;
        ccr_out = ccrout_q;
    end

    AST_WR_ONLY_SET:   assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (kind_q == OPK_BSET)); // R7
    AST_WR_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en); // R7
    AST_WR_THEN_DONE:  assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> done); // R9
    AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_BAD_IGNORED:   assert property (@(posedge clk) disable iff (!rst_n) (!busy && start && !dec_legal) |=> !busy); // R2
    AST_SET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (done && kind_q == OPK_BSET) |-> !taken); // R6
    AST_CLR_DECISION:  assert property (@(posedge clk) disable iff (!rst_n) (done && kind_q == OPK_BRCLR) |-> (taken == ((m_q & mask_q) == '0))); // R3
    AST_CARRY_KEPT:    assert property (@(posedge clk) disable iff (!rst_n) done |-> (ccr_out[0] == ccr_q[0])); // R8
endmodule

// File: tb/test_bitbr_unit.sv
module test_bitbr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [2:0]  amode = '0;
    logic [7:0]  m_in = '0, mask = '0, disp = '0;
    logic [15:0] pc_in = '0;
    logic [3:0]  ccr_in = '0;
    logic        busy, done, taken, wr_en;
    logic [15:0] next_pc;
    logic [7:0]  wr_data;
    logic [3:0]  ccr_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bitbr_unit i_bitbr_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .amode(amode),
        .m_in(m_in), .mask(mask), .disp(disp), .pc_in(pc_in), .ccr_in(ccr_in),
        .busy(busy), .done(done), .taken(taken), .next_pc(next_pc),
        .wr_en(wr_en), .wr_data(wr_data), .ccr_out(ccr_out)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [7:0] op, input logic [2:0] am);
        int l;
        case (am)
            3'd0: l = 4;
            3'd1: l = 5;
            3'd2: l = 4;
            3'd3: l = 5;
            default: l = 6;
        endcase
        if (op[3:0] == 4'hC) l = l - 1;
        return l;
    endfunction

    // One full instruction; hammer raises a second, different start while busy (R9).
    task automatic run_op(input logic [7:0] op, input logic [2:0] am, input logic [7:0] m,
                          input logic [7:0] mk, input logic [7:0] d, input logic [15:0] pc,
                          input logic [3:0] cc, input bit hammer);
        bit          is_set = (op[3:0] == 4'hC);
        logic        e_tk;
        logic [15:0] e_pc;
        logic [7:0]  e_wd = m | mk;
        logic [3:0]  e_cc;
        int          done_at = 0, wr_cnt = 0;
        logic [7:0]  wd_seen = '0;
        string       rq_tk = (op[3:0] == 4'hF) ? "R3" : (op[3:0] == 4'hE) ? "R4" : "R6";
        string       rq_pc = is_set ? "R6" : "R5";
        if (op[3:0] == 4'hF)      e_tk = ((m & mk) == 8'h00);
        else if (op[3:0] == 4'hE) e_tk = ((~m & mk) == 8'h00);
        else                      e_tk = 1'b0;
        e_pc = pc + 16'(exp_len(op, am)) + (e_tk ? {{8{d[7]}}, d} : 16'h0000);
        e_cc = is_set ? {e_wd[7], (e_wd == 8'h00), 1'b0, cc[0]} : cc;

        @(negedge clk);
        start = 1'b1; opcode = op; amode = am; m_in = m; mask = mk; disp = d; pc_in = pc; ccr_in = cc;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (hammer) begin
                    opcode = 8'h4C; amode = 3'd0; mask = 8'hFF; pc_in = 16'h1234;
                end else start = 1'b0;
            end
            if (k == 2) start = 1'b0;
            if (wr_en) begin wr_cnt++; wd_seen = wr_data; end
            if (done && done_at == 0) done_at = k;
        end
        chk("R9", "done latency", done_at, is_set ? 4 : 3);
        chk(rq_tk, "taken", taken, e_tk);
        chk(rq_pc, "next_pc", next_pc, e_pc);
        chk("R7", "write strobes", wr_cnt, is_set ? 1 : 0);
        if (is_set) chk("R7", "wr_data", wd_seen, e_wd);
        chk("R8", "ccr_out", ccr_out, e_cc);
        chk("R9", "idle after", busy, 1'b0);
    endtask

    task automatic bad_start(input logic [7:0] op, input logic [2:0] am);
        int seen = 0;
        @(negedge clk);
        start = 1'b1; opcode = op; amode = am;
        @(negedge clk);
        start = 1'b0;
        if (busy) seen++;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (busy || done || wr_en) seen++;
        end
        chk("R2", "activity after rejected start", seen, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", busy, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", busy, 1'b0);
        chk("R1", "done", done, 1'b0);
        chk("R1", "wr_en", wr_en, 1'b0);

        run_op(8'h4F, 3'd0, 8'hA5, 8'h5A, 8'h10, 16'h2000, 4'b0000, 0); // R3 clear taken
        run_op(8'h1F, 3'd1, 8'hA5, 8'h21, 8'h10, 16'h2000, 4'b1111, 0); // R3 not taken
        run_op(8'h0F, 3'd3, 8'hFF, 8'h00, 8'hF0, 16'h0004, 4'b0101, 0); // R3 zero mask, wrap
        run_op(8'h0E, 3'd4, 8'hF3, 8'hF0, 8'h80, 16'h0010, 4'b1010, 0); // R4 taken, wrap
        run_op(8'h4E, 3'd0, 8'h70, 8'hF0, 8'h7F, 16'hFFF0, 4'b0001, 0); // R4 not taken
        run_op(8'h0E, 3'd2, 8'h00, 8'h00, 8'h05, 16'h0100, 4'b0000, 0); // R4 zero mask
        run_op(8'h4C, 3'd0, 8'h00, 8'h00, 8'h20, 16'h3000, 4'b0011, 0); // R6 R8 zero result
        run_op(8'h1C, 3'd1, 8'h01, 8'h80, 8'h20, 16'h3000, 4'b0110, 0); // R7 R8 negative result
        run_op(8'h0C, 3'd3, 8'h12, 8'h21, 8'hFF, 16'hFFFE, 4'b1001, 0); // R6 wrap
        run_op(8'h0C, 3'd4, 8'h40, 8'h02, 8'h00, 16'h0400, 4'b0000, 0); // R6 idx16
        run_op(8'h0F, 3'd2, 8'h0F, 8'hF0, 8'h02, 16'h0500, 4'b0000, 1); // R9 start while busy
        bad_start(8'h4D, 3'd0); // R2 opcode outside the groups
        bad_start(8'h4F, 3'd1); // R2 class mismatch
        bad_start(8'h0C, 3'd0); // R2 indexed opcode with direct class
        bad_start(8'h2F, 3'd2); // R2 unknown high nibble

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule